// File: doc/BRIEF.md
# Direct-Mapped Write-Back Halfword Data Cache

This block connects a sixteen-entry, 16-bit register file to a byte-addressed 64 KiB main memory through an eight-line direct-mapped data cache. Each line holds an 8-byte block, a tag, a valid flag and a dirty flag. A request names one of two operations (load into a register, or store from a register), a 4-bit register number and an aligned 16-bit address. The cache splits the address into a 10-bit tag (`addr[15:6]`), a 3-bit line index (`addr[5:3]`) and a 3-bit byte offset (`addr[2:0]`). It moves one big-endian halfword between the register and the selected line. It then reports the address fields, whether the access hit, and the halfword that moved.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. From that edge until the cycle that reports the result, `busy` is high and `req_ready` is low; this is the only back-pressure on the request side. The result is a one-cycle pulse on `rsp_valid` and cannot be stalled. On a miss the block first writes a dirty victim back and then fills the line, one byte per memory handshake. A store miss allocates the line and does not write memory.

The memory port uses `mem_valid`/`mem_ready` with a read strobe and a write strobe. A byte moves on each edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the address, strobes and write data stay unchanged. Read data is sampled on the handshake edge.

Top module: `halfword_cache`

## Requirements
- R1: After reset all registers hold zero and every line is invalid. The first access therefore misses, and a store of any register reports data 0x0000.
- R2: Each result reports tag = addr[15:6], index = addr[5:3] and offset = addr[2:0]. For example, 0x58d6 gives tag 0x163, index 2 and offset 6.
- R3: A load writes {byte[a], byte[a+1]} into the named register, with the byte at the lower address as the high byte, and reports that value on `rsp_data`.
- R4: A store reports the named register's value and writes its high byte at offset a and its low byte at offset a+1 of the line. A later load of the same address returns that value.
- R5: An access whose index holds a valid line with a matching tag reports `rsp_hit`=1 and makes no memory handshake.
- R6: A miss reads exactly 8 bytes, in ascending order, from {new tag, index, 000}. A line filled by a load is clean, so replacing it later writes nothing back.
- R7: A store miss allocates the line and writes no byte to memory for the stored halfword. The line becomes dirty.
- R8: On a miss whose victim is valid and dirty, the block writes all 8 victim bytes to {old tag, index, 000} in ascending order before any fill read.
- R9: Each memory handshake moves one byte. The read and write strobes are never both high while `mem_valid` is high. Address, strobes and write data hold while `mem_ready` is low. No request is made while idle.
- R10: `req_ready` is high exactly when idle. `busy` rises on the edge after a request is taken and stays high through the single `rsp_valid` cycle. The block is idle again on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_store | input | 1 | 1 = store from register, 0 = load into register |
| req_reg | input | 4 | Register number |
| req_addr | input | 16 | Aligned byte address (bit 0 is 0) |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_store | output | 1 | Operation of the reported access |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_tag | output | 10 | Tag field of the address |
| rsp_index | output | 3 | Line index field |
| rsp_offset | output | 3 | Byte offset field |
| rsp_data | output | 16 | Halfword moved |
| mem_valid | output | 1 | Memory byte request |
| mem_ready | input | 1 | Memory accepts or returns the byte |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, sampled on the handshake |

## Verification
The bound checker watches the handshake rules on every cycle: strobe exclusivity, holding the memory request under back-pressure, the busy/ready/result pulse sequence, no memory traffic on hits, a full 8-byte fill on every miss, and write-back being all-or-nothing and completed before the first fill read. Only the bench's scenarios can show that the data is right. That covers big-endian halfword placement, register contents seen through later stores, hit and miss decisions against a reference tag model, the exact write-back and fill addresses, and written-back bytes matching the latest stored values. They also show that a store miss leaves memory unchanged until the line is evicted.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_XFER
  } dc_state_e;
endpackage

// File: rtl/dc_regfile.sv
module dc_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (we && (waddr == REG_W'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 8,
  parameter int TAG_W      = 10,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BLK_W     = LINE_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  // single-byte write used by the fill
  input  logic             byte_we,
  input  logic [OFF_W-1:0] byte_sel,
  input  logic [7:0]       byte_wdata,
  // fill completion: line becomes valid and clean under new_tag
  input  logic             fill_done,
  input  logic [TAG_W-1:0] new_tag,
  // halfword store: big-endian, marks the line dirty
  input  logic             hw_we,
  input  logic [OFF_W-1:0] hw_off,
  input  logic [15:0]      hw_wdata,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_block
);
  logic [NUM_LINES-1:0] valid_v;
  logic [NUM_LINES-1:0] dirty_v;
  logic [TAG_W-1:0]     tag_v  [NUM_LINES];
  logic [BLK_W-1:0]     data_v [NUM_LINES];

  logic [OFF_W-1:0] lo_off;
  assign lo_off = {hw_off[OFF_W-1:1], 1'b1};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic             sel;
    logic             valid_q;
    logic             dirty_q;
    logic [TAG_W-1:0] tag_q;
    logic [7:0]       bytes_q [LINE_BYTES];

    assign sel = (idx == IDX_W'(l));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        tag_q   <= '0;
      end else begin
        if (sel && fill_done) begin
          valid_q <= 1'b1;
          dirty_q <= 1'b0;
          tag_q   <= new_tag;
        end
        if (sel && hw_we) begin
          dirty_q <= 1'b1;
        end
      end
    end

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bytes_q[b] <= '0;
        end else if (sel && byte_we && (byte_sel == OFF_W'(b))) begin
          bytes_q[b] <= byte_wdata;
        end else if (sel && hw_we && (hw_off == OFF_W'(b))) begin
          bytes_q[b] <= hw_wdata[15:8];
        end else if (sel && hw_we && (lo_off == OFF_W'(b))) begin
          bytes_q[b] <= hw_wdata[7:0];
        end
      end
      assign data_v[l][b*8 +: 8] = bytes_q[b];
    end

    assign valid_v[l] = valid_q;
    assign dirty_v[l] = dirty_q;
    assign tag_v[l]   = tag_q;
  end

  assign rd_valid = valid_v[idx];
  assign rd_dirty = dirty_v[idx];
  assign rd_tag   = tag_v[idx];
  assign rd_block = data_v[idx];
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 8,
  parameter int NUM_REGS   = 16,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int REG_W     = $clog2(NUM_REGS),
  localparam int BLK_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_store,
  output logic              rsp_hit,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic [15:0]       rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  // line store side
  output logic [IDX_W-1:0]  ls_idx,
  output logic              ls_byte_we,
  output logic [OFF_W-1:0]  ls_byte_sel,
  output logic [7:0]        ls_byte_wdata,
  output logic              ls_fill_done,
  output logic [TAG_W-1:0]  ls_new_tag,
  output logic              ls_hw_we,
  output logic [OFF_W-1:0]  ls_hw_off,
  output logic [15:0]       ls_hw_wdata,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [BLK_W-1:0]  line_block,
  // register file side
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [15:0]       rf_wdata,
  input  logic [15:0]       rf_rdata
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);

  dc_state_e         state_q, state_d;
  logic              store_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hit_q;
  logic [OFF_W-1:0]  beat_q;

  logic [TAG_W-1:0] tag_f;
  logic [IDX_W-1:0] idx_f;
  logic [OFF_W-1:0] off_f;
  logic [OFF_W-1:0] off_lo;
  logic             lookup_hit;
  logic             beat_done;
  logic [15:0]      line_half;

  assign tag_f  = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_f  = addr_q[OFF_W +: IDX_W];
  assign off_f  = addr_q[OFF_W-1:0];
  assign off_lo = {off_f[OFF_W-1:1], 1'b1};

  assign lookup_hit = line_valid && (line_tag == tag_f);
  assign beat_done  = mem_valid && mem_ready;
  assign line_half  = {line_block[off_f*8 +: 8], line_block[off_lo*8 +: 8]};

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (lookup_hit)                   state_d = ST_XFER;
        else if (line_valid && line_dirty) state_d = ST_WB;
        else                               state_d = ST_FILL;
      end
      ST_WB:   if (beat_done && beat_q == LAST_BEAT) state_d = ST_FILL;
      ST_FILL: if (beat_done && beat_q == LAST_BEAT) state_d = ST_XFER;
      ST_XFER: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      reg_q   <= '0;
      addr_q  <= '0;
      hit_q   <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        store_q <= req_store;
        reg_q   <= req_reg;
        addr_q  <= req_addr;
      end
      if (state_q == ST_LOOK) begin
        hit_q  <= lookup_hit;
        beat_q <= '0;
      end else if (beat_done) begin
        beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + OFF_W'(1);
      end
    end
  end

  // handshake and result
  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign rsp_valid  = (state_q == ST_XFER);
  assign rsp_store  = store_q;
  assign rsp_hit    = hit_q;
  assign rsp_tag    = tag_f;
  assign rsp_index  = idx_f;
  assign rsp_offset = off_f;
  assign rsp_data   = store_q ? rf_rdata : line_half;

  // memory port: victim bytes go out under the old tag, fill under the new
  assign mem_valid = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_wr_en = (state_q == ST_WB);
  assign mem_rd_en = (state_q == ST_FILL);
  assign mem_addr  = (state_q == ST_WB) ? {line_tag, idx_f, beat_q}
                                        : {tag_f, idx_f, beat_q};
  assign mem_wdata = line_block[beat_q*8 +: 8];

  // line store controls
  assign ls_idx        = idx_f;
  assign ls_byte_we    = (state_q == ST_FILL) && beat_done;
  assign ls_byte_sel   = beat_q;
  assign ls_byte_wdata = mem_rdata;
  assign ls_fill_done  = (state_q == ST_FILL) && beat_done && (beat_q == LAST_BEAT);
  assign ls_new_tag    = tag_f;
  assign ls_hw_we      = (state_q == ST_XFER) && store_q;
  assign ls_hw_off     = off_f;
  assign ls_hw_wdata   = rf_rdata;

  // register file controls
  assign rf_we    = (state_q == ST_XFER) && !store_q;
  assign rf_addr  = reg_q;
  assign rf_wdata = line_half;
endmodule

// File: rtl/halfword_cache.sv
module halfword_cache #(
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 8,
  parameter int LINE_BYTES = 8,
  parameter int NUM_REGS   = 16,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_store,
  output logic              rsp_hit,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic [15:0]       rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int BLK_W = LINE_BYTES * 8;

  logic [IDX_W-1:0] ls_idx;
  logic             ls_byte_we;
  logic [OFF_W-1:0] ls_byte_sel;
  logic [7:0]       ls_byte_wdata;
  logic             ls_fill_done;
  logic [TAG_W-1:0] ls_new_tag;
  logic             ls_hw_we;
  logic [OFF_W-1:0] ls_hw_off;
  logic [15:0]      ls_hw_wdata;
  logic             line_valid;
  logic             line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [BLK_W-1:0] line_block;
  logic             rf_we;
  logic [REG_W-1:0] rf_addr;
  logic [15:0]      rf_wdata;
  logic [15:0]      rf_rdata;

  dc_ctrl #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES),
    .LINE_BYTES(LINE_BYTES), .NUM_REGS(NUM_REGS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_reg(req_reg), .req_addr(req_addr), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_store(rsp_store), .rsp_hit(rsp_hit),
    .rsp_tag(rsp_tag), .rsp_index(rsp_index), .rsp_offset(rsp_offset),
    .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .ls_idx(ls_idx), .ls_byte_we(ls_byte_we), .ls_byte_sel(ls_byte_sel),
    .ls_byte_wdata(ls_byte_wdata), .ls_fill_done(ls_fill_done),
    .ls_new_tag(ls_new_tag), .ls_hw_we(ls_hw_we), .ls_hw_off(ls_hw_off),
    .ls_hw_wdata(ls_hw_wdata),
    .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
    .line_block(line_block),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  dc_line_store #(
    .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n), .idx(ls_idx),
    .byte_we(ls_byte_we), .byte_sel(ls_byte_sel), .byte_wdata(ls_byte_wdata),
    .fill_done(ls_fill_done), .new_tag(ls_new_tag),
    .hw_we(ls_hw_we), .hw_off(ls_hw_off), .hw_wdata(ls_hw_wdata),
    .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
    .rd_block(line_block)
  );

  dc_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(16)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_addr),
    .wdata(rf_wdata), .raddr(rf_addr), .rdata(rf_rdata)
  );
endmodule

// File: rtl/halfword_cache_chk.sv
module halfword_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int TAG_W      = 10,
  parameter int IDX_W      = 3,
  parameter int OFF_W      = 3,
  parameter int REG_W      = 4,
  localparam int CNT_W     = $clog2(LINE_BYTES) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic [REG_W-1:0]  req_reg,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_store,
  input logic              rsp_hit,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [IDX_W-1:0]  rsp_index,
  input logic [OFF_W-1:0]  rsp_offset,
  input logic [15:0]       rsp_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata
);
  logic [CNT_W-1:0] rd_cnt, wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || (req_valid && req_ready)) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (mem_valid && mem_ready) begin
      if (mem_rd_en) rd_cnt <= rd_cnt + CNT_W'(1);
      if (mem_wr_en) wr_cnt <= wr_cnt + CNT_W'(1);
    end
  end

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);
  // R10
  rsp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy && !req_ready);
  // R10
  rsp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && req_ready && !rsp_valid);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_rd_en != mem_wr_en));
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
      && $stable(mem_wr_en) && $stable(mem_wdata));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
  // R5
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> (rd_cnt == '0) && (wr_cnt == '0));
  // R6
  miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rd_cnt == CNT_W'(LINE_BYTES)));
  // R8
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_wr_en |-> (rd_cnt == '0));
  // R8
  wb_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (wr_cnt == '0) || (wr_cnt == CNT_W'(LINE_BYTES)));
endmodule

bind halfword_cache halfword_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W),
  .IDX_W(IDX_W), .OFF_W(OFF_W), .REG_W(REG_W)
) u_chk (.*);

// File: tb/tb_halfword_cache.sv
module tb_halfword_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [3:0]  req_reg = '0;
  logic [15:0] req_addr = '0;
  logic        busy, rsp_valid, rsp_store, rsp_hit;
  logic [9:0]  rsp_tag;
  logic [2:0]  rsp_index, rsp_offset;
  logic [15:0] rsp_data;
  logic        mem_valid, mem_rd_en, mem_wr_en;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #2 clk = ~clk;

  halfword_cache dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ready_pct = 75;

  logic [7:0]  back_mem [int];
  logic [7:0]  ref_mem  [int];
  logic [15:0] ref_reg  [16];
  logic        ref_v [8];
  logic        ref_d [8];
  logic [9:0]  ref_t [8];

  int mon_rd, mon_wr;
  int exp_wb_base, exp_fill_base;

  function automatic logic [7:0] init_byte(int a);
    logic [15:0] x = 16'(a);
    return x[7:0] ^ x[15:8] ^ 8'h5a;
  endfunction

  function automatic logic [7:0] back_rd(int a);
    return back_mem.exists(a) ? back_mem[a] : init_byte(a);
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: random back-pressure, byte read data presented ahead of the edge
  always @(negedge clk) begin
    mem_ready <= (($urandom % 100) < 32'(ready_pct));
    mem_rdata <= back_rd(int'(mem_addr));
  end

  // memory-side monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        mon_rd = 0;
        mon_wr = 0;
      end else if (mem_valid && mem_ready) begin
        if (mem_wr_en) begin
          check("R8", "writeback order", 32'(mon_rd), 32'd0);
          check("R8", "writeback addr", 32'(mem_addr), 32'(exp_wb_base + mon_wr));
          check("R8", "writeback byte", 32'(mem_wdata), 32'(ref_rd(int'(mem_addr))));
          back_mem[int'(mem_addr)] = mem_wdata;
          mon_wr++;
        end else begin
          check("R6", "fill addr", 32'(mem_addr), 32'(exp_fill_base + mon_rd));
          mon_rd++;
        end
      end
    end
  end

  task automatic access(input bit st, input int r, input logic [15:0] a);
    logic [9:0]  tg  = a[15:6];
    logic [2:0]  ix  = a[5:3];
    logic [2:0]  of  = a[2:0];
    logic        eh  = ref_v[ix] && (ref_t[ix] == tg);
    logic        ewb = !eh && ref_v[ix] && ref_d[ix];
    logic [15:0] mem_half = {ref_rd(int'(a)), ref_rd(int'(a) + 1)};
    logic [15:0] ed  = st ? ref_reg[r] : mem_half;
    int cyc = 0;
    exp_wb_base   = int'({ref_t[ix], ix, 3'b000});
    exp_fill_base = int'({tg, ix, 3'b000});
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_store = st;
    req_reg   = 4'(r);
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!rsp_valid) begin
      check("R10", "result timeout", 32'd0, 32'd1);
      return;
    end
    check("R2", "tag", 32'(rsp_tag), 32'(tg));
    check("R2", "index", 32'(rsp_index), 32'(ix));
    check("R2", "offset", 32'(rsp_offset), 32'(of));
    check("R5", "hit flag", 32'(rsp_hit), 32'(eh));
    check(st ? "R4" : "R3", "data", 32'(rsp_data), 32'(ed));
    check("R10", "op echo", 32'(rsp_store), 32'(st));
    check("R10", "busy at result", 32'(busy), 32'd1);
    check("R6", "fill count", 32'(mon_rd), eh ? 32'd0 : 32'd8);
    check("R8", "writeback count", 32'(mon_wr), ewb ? 32'd8 : 32'd0);
    if (st && !eh)
      check("R7", "memory untouched by store miss",
            32'({back_rd(int'(a)), back_rd(int'(a) + 1)}), 32'(mem_half));
    @(negedge clk);
    check("R10", "idle after result", 32'({busy, req_ready}), 32'b01);
    // reference update
    if (!eh) begin
      ref_v[ix] = 1'b1;
      ref_t[ix] = tg;
      ref_d[ix] = 1'b0;
    end
    if (st) begin
      ref_d[ix] = 1'b1;
      ref_mem[int'(a)]     = ref_reg[r][15:8];
      ref_mem[int'(a) + 1] = ref_reg[r][7:0];
    end else begin
      ref_reg[r] = ed;
    end
  endtask

  initial begin
    void'($urandom(32'h0c0ffee5));
    for (int i = 0; i < 16; i++) ref_reg[i] = '0;
    for (int i = 0; i < 8; i++) begin
      ref_v[i] = 1'b0; ref_d[i] = 1'b0; ref_t[i] = '0;
    end
    repeat (4) @(negedge clk);
    check("R10", "ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset outputs", 32'({busy, rsp_valid, mem_valid}), 32'd0);

    // R1/R2: first store of a zero register, clean miss at 0x58d6
    access(1'b1, 3, 16'h58d6);
    // R3 + R8: load conflicting on line 2 evicts the dirty line
    access(1'b0, 5, 16'h0214);
    // R4/R5: store hit then reload
    access(1'b1, 5, 16'h0216);
    access(1'b0, 6, 16'h0216);
    // R8: evict again, old stored zero comes back
    access(1'b0, 7, 16'h58d6);
    // R6: clean line replaced without write-back, high tag
    access(1'b0, 8, 16'hffd6);
    access(1'b0, 9, 16'h0010);
    // R9: long back-pressure
    ready_pct = 10;
    access(1'b1, 9, 16'h3f38);
    access(1'b0, 1, 16'h0038);
    ready_pct = 75;

    for (int n = 0; n < 600; n++) begin
      logic [9:0]  tg;
      logic [15:0] a;
      case ($urandom % 5)
        0: tg = 10'h000;
        1: tg = 10'h001;
        2: tg = 10'h163;
        3: tg = 10'h3ff;
        default: tg = 10'h0a2;
      endcase
      a = {tg, 3'($urandom), 2'($urandom), 1'b0};
      access(1'($urandom), int'($urandom % 16), a);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule